// File: doc/BRIEF.md
# Recovered Clock Frequency Range Monitor

This block checks that a clock recovered from a serial line runs close to the rate set by a local reference clock. Time is cut into windows of 4096 recovered byte-clock cycles. The block counts reference-clock edges across each window and compares the total with the count it expects. The reference may run at the character rate, which gives an expected count of 4096. It may instead run at half that rate, which gives 2048. If the measured count is more than 1500 ppm away from the expected count, the block drives a force request to the loop. The request holds the loop on the reference for one window and then lets it go, so that the loop can try again to lock onto the line data.

The reference-side count reaches the recovered-clock side through a toggle request and acknowledge handshake. The count is never sampled as a moving multi-bit bus. A window that overlaps a force interval does not describe a free-running loop, so its result is discarded. The first window after reset or after the channel is enabled has no clean starting point, so its result is discarded too. A status output reports the most recent valid verdict and stays high while the channel is disabled.

Top module: `rclk_range_mon`

## Requirements
- R1: Windows are 4096 recovered-clock cycles long and start at the first enabled edge. The force output changes only on the edge where the window phase equals 32 (counting from 0), or on the edge after a disable.
- R2: With `half_rate` = 1 the expected count is 2048 and the tolerance is 3 counts. With `half_rate` = 0 the expected count is 4096 and the tolerance is 6 counts. Each tolerance is 1500 ppm of the expected count, truncated to an integer.
- R3: A clean window whose reference count lies within tolerance of the expected count never causes `force_ref` to go high.
- R4: A clean window whose count lies outside tolerance drives `force_ref` high for exactly 4096 cycles, unless a disable cuts the interval short.
- R5: After `force_ref` is released it stays low for at least 8192 cycles. The window that holds the release is discarded, and only the window after it can trigger a new force.
- R6: `range_fault` is high whenever `force_ref` is high. Each valid verdict updates it: 1 for out of range, 0 for in range. Between valid verdicts it holds its value.
- R7: After reset, and after each enable, `range_fault` = 1 and `force_ref` = 0 until the first valid verdict. That verdict takes effect on enabled edge 2·4096+32.
- R8: While `chan_off` = 1 the window restarts and all verdict history is cleared. `force_ref` goes low and `range_fault` goes high on the next recovered-clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rclk | input | 1 | Recovered byte clock; the monitor's main clock |
| ref_clk | input | 1 | Local reference clock at the character rate or half of it |
| rst_n | input | 1 | Active-low asynchronous reset for both clock domains |
| chan_off | input | 1 | Channel disable, synchronous to rclk |
| half_rate | input | 1 | 1: reference at half character rate (2048 expected), 0: full rate (4096) |
| force_ref | output | 1 | Holds the loop on the reference for one window |
| range_fault | output | 1 | Out-of-range / link-fault status |

## Verification
A corrupted window counter or decision phase moves the edges of `force_ref` away from phase 32 of a window, which shows within one window of 4096 cycles. A faulty count transfer or a wrong tolerance produces the wrong verdict, so `force_ref` and `range_fault` differ from the expected values on enabled edge 8224 of a run. The reference clock in each test case sits well inside or well outside the limit, so a one-count uncertainty at the clock crossing cannot change the outcome. A broken clean-window flag shows as a force pulse that is longer or shorter than 4096 cycles, or that comes back too early. The model follows the repeating pattern of one window forced and two windows not forced, and catches this on the first pulse it affects.

// File: rtl/rclk_range_mon.sv
module rclk_range_mon #(
  parameter int WIN_LOG2  = 12,
  parameter int PPM       = 1500,
  parameter int DECIDE_AT = 32
) (
  input  logic rclk,
  input  logic ref_clk,
  input  logic rst_n,
  input  logic chan_off,
  input  logic half_rate,
  output logic force_ref,
  output logic range_fault
);
  localparam int WIN = 1 << WIN_LOG2;
  localparam int CW  = WIN_LOG2 + 2;
  localparam logic [CW-1:0] EXP_F = CW'(WIN);
  localparam logic [CW-1:0] EXP_H = CW'(WIN / 2);
  localparam logic [CW-1:0] TOL_F = CW'((WIN * PPM) / 1000000);
  localparam logic [CW-1:0] TOL_H = CW'(((WIN / 2) * PPM) / 1000000);

  logic [WIN_LOG2-1:0] wcnt;
  logic mark_t, arm, cur_ok, prev_ok, bad_q;

  wire wrap   = &wcnt;
  wire decide = (wcnt == WIN_LOG2'(DECIDE_AT));

  // reference domain: count edges between consecutive window markers
  logic [2:0]    mark_s;
  logic [CW-1:0] rcnt, snap;
  logic          ack_t;

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      mark_s <= '0;
      rcnt   <= '0;
      snap   <= '0;
      ack_t  <= 1'b0;
    end else begin
      mark_s <= {mark_s[1:0], mark_t};
      if (mark_s[2] ^ mark_s[1]) begin
        snap  <= rcnt;
        rcnt  <= CW'(1);
        ack_t <= ~ack_t;
      end else begin
        rcnt <= rcnt + 1'b1;
      end
    end
  end

  // recovered domain: pick up the snapshot once the acknowledge arrives
  logic [2:0] ack_s;
  wire ack_new = ack_s[2] ^ ack_s[1];

  wire [CW-1:0]      exp_cnt = half_rate ? EXP_H : EXP_F;
  wire [CW-1:0]      tol     = half_rate ? TOL_H : TOL_F;
  wire signed [CW:0] diff    = $signed({1'b0, snap}) - $signed({1'b0, exp_cnt});
  wire [CW:0]        mag     = diff[CW] ? CW'(1'b0) - diff : diff;
  wire               bad     = mag > {1'b0, tol};

  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n) begin
      ack_s <= '0;
      bad_q <= 1'b0;
    end else begin
      ack_s <= {ack_s[1:0], ack_t};
      if (ack_new) bad_q <= bad;
    end
  end

  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n) begin
      wcnt        <= '0;
      mark_t      <= 1'b0;
      arm         <= 1'b0;
      cur_ok      <= 1'b1;
      prev_ok     <= 1'b0;
      force_ref   <= 1'b0;
      range_fault <= 1'b1;
    end else if (chan_off) begin
      wcnt        <= '0;
      arm         <= 1'b0;
      cur_ok      <= 1'b1;
      prev_ok     <= 1'b0;
      force_ref   <= 1'b0;
      range_fault <= 1'b1;
    end else begin
      wcnt <= wcnt + 1'b1;
      if (wrap) begin
        mark_t  <= ~mark_t;
        prev_ok <= cur_ok & arm & ~force_ref;
        cur_ok  <= 1'b1;
        arm     <= 1'b1;
      end else if (force_ref) begin
        cur_ok <= 1'b0;
      end
      if (decide) begin
        if (force_ref) begin
          force_ref <= 1'b0;
        end else if (prev_ok) begin
          force_ref   <= bad_q;
          range_fault <= bad_q;
        end
      end
    end
  end
endmodule

module rclk_range_mon_chk #(
  parameter int WIN_LOG2  = 12,
  parameter int DECIDE_AT = 32
) (
  input logic                rclk,
  input logic                rst_n,
  input logic                chan_off,
  input logic                force_ref,
  input logic                range_fault,
  input logic [WIN_LOG2-1:0] wcnt
);
  localparam int WIN = 1 << WIN_LOG2;
  localparam int RW  = WIN_LOG2 + 2;

  logic [RW-1:0] on_run, off_run;
  logic          seen_rel;

  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n) begin
      on_run   <= '0;
      off_run  <= '0;
      seen_rel <= 1'b0;
    end else if (force_ref) begin
      on_run  <= on_run + 1'b1;
      off_run <= '0;
    end else begin
      on_run <= '0;
      if (on_run != '0) seen_rel <= 1'b1;
      if (off_run != RW'(2 * WIN)) off_run <= off_run + 1'b1;
    end
  end

  p_decide_phase_r1: assert property (@(posedge rclk) disable iff (!rst_n)
    (!$stable(force_ref) && !$past(chan_off)) |-> ($past(wcnt) == WIN_LOG2'(DECIDE_AT)));

  p_force_len_r4: assert property (@(posedge rclk) disable iff (!rst_n)
    ($fell(force_ref) && !$past(chan_off)) |-> (on_run == RW'(WIN)));

  p_relock_gap_r5: assert property (@(posedge rclk) disable iff (!rst_n)
    ($rose(force_ref) && seen_rel) |-> (off_run >= RW'(2 * WIN)));

  p_fault_covers_r6: assert property (@(posedge rclk) disable iff (!rst_n)
    force_ref |-> range_fault);

  p_disable_r8: assert property (@(posedge rclk) disable iff (!rst_n)
    chan_off |=> (!force_ref && range_fault));
endmodule

bind rclk_range_mon rclk_range_mon_chk #(.WIN_LOG2(WIN_LOG2), .DECIDE_AT(DECIDE_AT)) u_chk (
  .rclk(rclk), .rst_n(rst_n), .chan_off(chan_off),
  .force_ref(force_ref), .range_fault(range_fault), .wcnt(wcnt)
);

// File: tb/rclk_range_mon_test.sv
`timescale 1ns/1ps
module rclk_range_mon_test;
  localparam int W   = 4096;
  localparam int DEC = 32;

  logic rclk = 1'b0, ref_clk = 1'b0, rst_n = 1'b0;
  logic chan_off = 1'b1, half_rate = 1'b0;
  logic force_ref, range_fault;

  int  vectors = 0, errors = 0;
  bit  done = 1'b0;
  real ref_half = 5.0;
  bit  exp_bad = 1'b0;
  int  en_edges = 0;
  bit  exp_force = 1'b0, exp_fault = 1'b1;
  string tag_force = "R7", tag_fault = "R7";

  rclk_range_mon uut (
    .rclk(rclk), .ref_clk(ref_clk), .rst_n(rst_n), .chan_off(chan_off),
    .half_rate(half_rate), .force_ref(force_ref), .range_fault(range_fault)
  );

  always #5 rclk = ~rclk;
  initial forever #(ref_half) ref_clk = ~ref_clk;

  // behavioural model: expected outputs from enabled-edge count and verdict
  always @(posedge rclk) begin
    if (!rst_n || chan_off) begin
      en_edges  = 0;
      exp_force = 1'b0;
      exp_fault = 1'b1;
      tag_force = rst_n ? "R8" : "R7";
      tag_fault = tag_force;
    end else begin
      int k;
      k = en_edges - DEC;
      en_edges++;
      if (k < 2 * W) begin
        exp_force = 1'b0;
        exp_fault = 1'b1;
        tag_force = (k >= 0 && k % W == 0) ? "R1" : "R7";
        tag_fault = "R7";
      end else begin
        int ph;
        ph = ((k / W) - 2) % 3;
        exp_fault = exp_bad;
        exp_force = exp_bad && (ph == 0);
        tag_force = !exp_bad ? "R3" : (k % W == 0) ? "R1" : (ph == 0) ? "R4" : "R5";
        tag_fault = half_rate ? "R2" : "R6";
      end
    end
  end

  always @(negedge rclk) begin
    if (!done) begin
      vectors++;
      if (force_ref !== exp_force) begin
        errors++;
        $display("FAIL %s force_ref: actual %b expected %b at %0t", tag_force, force_ref, exp_force, $time);
      end
      if (range_fault !== exp_fault) begin
        errors++;
        $display("FAIL %s range_fault: actual %b expected %b at %0t", tag_fault, range_fault, exp_fault, $time);
      end
    end
  end

  // R2/R3: verdict from the ideal count over 4096 recovered cycles (10 ns each)
  task automatic run_case(input bit half, input int ppm, input int cycles);
    real base, per, cnt, nominal, tol, dev;
    @(negedge rclk);
    chan_off = 1'b1;
    half_rate = half;
    base = half ? 20.0 : 10.0;
    per = base / (1.0 + ppm * 1.0e-6);
    ref_half = per / 2.0;
    nominal = half ? W / 2 : W;
    tol = $floor(nominal * 1500.0 / 1.0e6);
    cnt = (W * 10.0) / per;
    dev = cnt - nominal;
    if (dev < 0.0) dev = -dev;
    exp_bad = dev > tol;
    repeat (20) @(negedge rclk);
    chan_off = 1'b0;
    repeat (cycles) @(negedge rclk);
  endtask

  initial begin
    repeat (4) @(negedge rclk);   // R7: reset state checked each cycle
    rst_n = 1'b1;
    run_case(1'b0,     0, 6 * W);  // R3 in range, full rate
    run_case(1'b0, -3000, 6 * W);  // R4 slow reference; ends inside a pulse (R8)
    run_case(1'b0,  1000, 6 * W);  // R3 within tolerance
    run_case(1'b0,  3000, 6 * W);  // R4 R5 fast reference
    run_case(1'b1,     0, 6 * W);  // R2 half rate in range
    run_case(1'b1,  4000, 6 * W);  // R2 half rate out of range
    run_case(1'b1,  -500, 2 * W + 100); // R2 R6 fault clears after a good verdict
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge rclk);
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule